// File: doc/BRIEF.md
# Segmented Address Translation Unit

This block keeps six segment selector registers and, beside each one, a cached segment descriptor. A pipeline stage hands it a segment number, an offset and a read/write flag. One clock later it returns a translated address or a fault code. After reset it works in real mode. In that mode the selector is shifted left by four bits and added to the low 16 bits of the offset, which gives a 20-bit address. Once software sets the mode bit, the block switches to protected mode. There it adds the cached descriptor base to the full offset, and it checks the offset against the cached limit and the request against the cached access bits.

Selectors are loaded through two paths. The data-move port can load the five data segments. The code segment can be loaded only through a separate control-flow port. A data-move write aimed at the code segment, or at an index that does not exist, is dropped and reported one cycle later. A separate fill port writes descriptor caches directly. Descriptors are never fetched from memory, and no paging is done.

Segment index encoding used on every port: 0 = code segment, 1 = data, 2 = stack, 3 = extra, 4 = extra F, 5 = extra G. Indices 6 and 7 are not valid.

Top module: `seg_xlate_unit`

## Requirements
- R1: After reset the block is in real mode, all six selectors are 0, every descriptor is marked not present, and both rsp_valid and wr_reject are low.
- R2: In real mode the response address is (selector << 4) + req_ofs[15:0], zero-extended to the output width. The upper offset bits are ignored, and the fault code is always 0 (none).
- R3: A real-mode sum that exceeds 20 bits wraps modulo 2^20. For example, selector FFFFh with offset FFFFh gives 0FFEFh.
- R4: A pulse on mode_wr loads mode_prot (1 = protected) into the mode bit, effective for requests from the next cycle on. In protected mode a request that does not fault returns (descriptor base + req_ofs) modulo 2^32.
- R5: In protected mode, an offset strictly greater than the 20-bit limit gives fault code 1 (limit) with address 0. An offset equal to the limit is accepted.
- R6: In protected mode, a non-present descriptor, a read of a non-readable segment or a write of a non-writable segment gives fault code 2 (access) with address 0. This check takes priority over the limit check. Fault code 3 never occurs.
- R7: A data-move write to indices 1..5 replaces that selector. A data-move write to index 0 (code segment) or to index 6 or 7 changes no selector, and wr_reject is high for exactly the following cycle.
- R8: cs_ld_en loads cs_ld_val into the code-segment selector. It may coincide with a data-move write to another segment, and both then take effect.
- R9: Every cycle with req_valid high is followed by exactly one cycle of rsp_valid high. rsp_valid is low in any cycle that does not follow a request.
- R10: A descriptor fill updates the cached base, limit and access bits of segment fill_idx and leaves every selector, and the real-mode translation, unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load the mode bit this cycle |
| mode_prot | input | 1 | New mode value: 1 protected, 0 real |
| seg_wr_en | input | 1 | Data-move selector write |
| seg_wr_idx | input | 3 | Target segment index of the data-move write |
| seg_wr_val | input | 16 | Selector value to write |
| cs_ld_en | input | 1 | Control-flow load of the code-segment selector |
| cs_ld_val | input | 16 | Code-segment selector value |
| fill_en | input | 1 | Descriptor cache fill |
| fill_idx | input | 3 | Segment index whose descriptor is filled |
| fill_base | input | 32 | Descriptor base address |
| fill_limit | input | 20 | Descriptor limit (last valid byte offset) |
| fill_present | input | 1 | Descriptor present bit |
| fill_read | input | 1 | Segment readable bit |
| fill_write | input | 1 | Segment writable bit |
| req_valid | input | 1 | Translate request strobe |
| req_seg | input | 3 | Segment index of the request |
| req_ofs | input | 32 | Offset within the segment |
| req_write | input | 1 | 1 for a write access, 0 for a read |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_addr | output | 32 | Translated address, 0 on a fault |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 access or not present |
| wr_reject | output | 1 | The data-move write of the previous cycle was dropped |

## Verification
The bench builds the unit with its default parameters: 16-bit selectors, 32-bit offsets and bases, 20-bit limits and the permission check enabled. Because the offset is wider than the limit, one request can exceed the limit only through its upper offset bits. Because the base is 32 bits wide, a base near the top of the space shows the protected-mode sum wrapping. Because the real-mode width is 20 bits, the FFFFh:FFFFh wrap fits inside the output, and the high output bits can be checked to stay zero. With the permission check enabled, the access-fault ordering against the limit can be exercised.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

   localparam int unsigned SEG_COUNT = 6;

   typedef enum logic [2:0] {
      SEG_CODE  = 3'd0,
      SEG_DATA  = 3'd1,
      SEG_STACK = 3'd2,
      SEG_EXTRA = 3'd3,
      SEG_EXF   = 3'd4,
      SEG_EXG   = 3'd5
   } seg_id_e;

   typedef enum logic [1:0] {
      FLT_NONE   = 2'd0,
      FLT_LIMIT  = 2'd1,
      FLT_ACCESS = 2'd2
   } fault_e;

   typedef struct packed {
      logic present;
      logic rd_ok;
      logic wr_ok;
   } seg_perm_t;

endpackage

// File: rtl/seg_bank.sv
module seg_bank
   import seg_xlate_pkg::*;
#(
   parameter int unsigned NSEG   = 6,
   parameter int unsigned SEL_W  = 16,
   parameter int unsigned BASE_W = 32,
   parameter int unsigned LIM_W  = 20,
   parameter int unsigned IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dwr_en,
   input  logic [IDX_W-1:0]  dwr_idx,
   input  logic [SEL_W-1:0]  dwr_val,
   input  logic              cs_ld_en,
   input  logic [SEL_W-1:0]  cs_ld_val,
   input  logic              fill_en,
   input  logic [IDX_W-1:0]  fill_idx,
   input  logic [BASE_W-1:0] fill_base,
   input  logic [LIM_W-1:0]  fill_lim,
   input  seg_perm_t         fill_perm,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [SEL_W-1:0]  rd_sel,
   output logic [BASE_W-1:0] rd_base,
   output logic [LIM_W-1:0]  rd_lim,
   output seg_perm_t         rd_perm,
   output logic [SEL_W-1:0]  code_sel,
   output logic              dwr_reject
);

   localparam int unsigned PERM_W = $bits(seg_perm_t);

   logic [NSEG*SEL_W-1:0]  sel_flat;
   logic [NSEG*BASE_W-1:0] base_flat;
   logic [NSEG*LIM_W-1:0]  lim_flat;
   logic [NSEG*PERM_W-1:0] perm_flat;

   if ((1 << IDX_W) < NSEG) begin : g_bad_idx
      $error("seg_bank: IDX_W too narrow for NSEG");
   end

   for (genvar g = 0; g < NSEG; g++) begin : g_seg
      logic [SEL_W-1:0]  sel_q;
      logic [BASE_W-1:0] base_q;
      logic [LIM_W-1:0]  lim_q;
      seg_perm_t         perm_q;
      logic              sel_load;
      logic [SEL_W-1:0]  sel_next;

      if (g == 0) begin : g_code
         assign sel_load = cs_ld_en;
         assign sel_next = cs_ld_val;
      end else begin : g_data
         assign sel_load = dwr_en && (dwr_idx == IDX_W'(g));
         assign sel_next = dwr_val;
      end

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            sel_q  <= '0;
            base_q <= '0;
            lim_q  <= '0;
            perm_q <= '0;
         end else begin
            if (sel_load) sel_q <= sel_next;
            if (fill_en && (fill_idx == IDX_W'(g))) begin
               base_q <= fill_base;
               lim_q  <= fill_lim;
               perm_q <= fill_perm;
            end
         end
      end

      assign sel_flat[g*SEL_W +: SEL_W]    = sel_q;
      assign base_flat[g*BASE_W +: BASE_W] = base_q;
      assign lim_flat[g*LIM_W +: LIM_W]    = lim_q;
      assign perm_flat[g*PERM_W +: PERM_W] = perm_q;
   end

   always_comb begin
      rd_sel  = '0;
      rd_base = '0;
      rd_lim  = '0;
      rd_perm = '0;
      for (int i = 0; i < NSEG; i++) begin
         if (rd_idx == IDX_W'(i)) begin
            rd_sel  = sel_flat[i*SEL_W +: SEL_W];
            rd_base = base_flat[i*BASE_W +: BASE_W];
            rd_lim  = lim_flat[i*LIM_W +: LIM_W];
            rd_perm = perm_flat[i*PERM_W +: PERM_W];
         end
      end
   end

   assign code_sel   = sel_flat[SEL_W-1:0];
   assign dwr_reject = dwr_en && ((dwr_idx == '0) || (dwr_idx >= IDX_W'(NSEG)));

endmodule

// File: rtl/seg_real_xlate.sv
module seg_real_xlate #(
   parameter int unsigned SEL_W   = 16,
   parameter int unsigned ROFS_W  = 16,
   parameter int unsigned REAL_AW = 20,
   parameter int unsigned OUT_W   = 32
) (
   input  logic [SEL_W-1:0]  sel,
   input  logic [ROFS_W-1:0] ofs,
   output logic [OUT_W-1:0]  addr
);

   localparam int unsigned SHIFT = REAL_AW - SEL_W;

   if (REAL_AW <= SEL_W || ROFS_W >= REAL_AW || OUT_W < REAL_AW) begin : g_bad_cfg
      $error("seg_real_xlate: inconsistent widths");
   end

   logic [REAL_AW-1:0] sum;

   assign sum  = {sel, {SHIFT{1'b0}}} + {{(REAL_AW-ROFS_W){1'b0}}, ofs};

   if (OUT_W > REAL_AW) begin : g_ext
      assign addr = {{(OUT_W-REAL_AW){1'b0}}, sum};
   end else begin : g_same
      assign addr = sum;
   end

endmodule

// File: rtl/seg_prot_check.sv
module seg_prot_check
   import seg_xlate_pkg::*;
#(
   parameter int unsigned OFS_W      = 32,
   parameter int unsigned BASE_W     = 32,
   parameter int unsigned LIM_W      = 20,
   parameter bit          PERM_CHECK = 1'b1
) (
   input  logic [OFS_W-1:0]  ofs,
   input  logic              is_write,
   input  logic [BASE_W-1:0] base,
   input  logic [LIM_W-1:0]  lim,
   input  seg_perm_t         perm,
   output logic [BASE_W-1:0] addr,
   output fault_e            fault
);

   if (OFS_W < LIM_W || OFS_W > BASE_W) begin : g_bad_cfg
      $error("seg_prot_check: need LIM_W <= OFS_W <= BASE_W");
   end

   logic beyond;
   logic denied;

   if (OFS_W > LIM_W) begin : g_wide_ofs
      assign beyond = (|ofs[OFS_W-1:LIM_W]) || (ofs[LIM_W-1:0] > lim);
   end else begin : g_equal_ofs
      assign beyond = ofs > lim;
   end

   if (PERM_CHECK) begin : g_perm
      assign denied = !perm.present || (is_write ? !perm.wr_ok : !perm.rd_ok);
   end else begin : g_present_only
      assign denied = !perm.present;
   end

   always_comb begin
      if (denied)      fault = FLT_ACCESS;
      else if (beyond) fault = FLT_LIMIT;
      else             fault = FLT_NONE;
   end

   assign addr = base + BASE_W'(ofs);

endmodule

// File: rtl/seg_xlate_unit.sv
module seg_xlate_unit
   import seg_xlate_pkg::*;
#(
   parameter int unsigned SEL_W      = 16,
   parameter int unsigned OFS_W      = 32,
   parameter int unsigned BASE_W     = 32,
   parameter int unsigned LIM_W      = 20,
   parameter int unsigned REAL_AW    = 20,
   parameter bit          PERM_CHECK = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              mode_wr,
   input  logic              mode_prot,
   input  logic              seg_wr_en,
   input  logic [2:0]        seg_wr_idx,
   input  logic [SEL_W-1:0]  seg_wr_val,
   input  logic              cs_ld_en,
   input  logic [SEL_W-1:0]  cs_ld_val,
   input  logic              fill_en,
   input  logic [2:0]        fill_idx,
   input  logic [BASE_W-1:0] fill_base,
   input  logic [LIM_W-1:0]  fill_limit,
   input  logic              fill_present,
   input  logic              fill_read,
   input  logic              fill_write,
   input  logic              req_valid,
   input  logic [2:0]        req_seg,
   input  logic [OFS_W-1:0]  req_ofs,
   input  logic              req_write,
   output logic              rsp_valid,
   output logic [BASE_W-1:0] rsp_addr,
   output logic [1:0]        rsp_fault,
   output logic              wr_reject
);

   localparam int unsigned NSEG   = SEG_COUNT;
   localparam int unsigned IDX_W  = 3;
   localparam int unsigned ROFS_W = SEL_W;

   if (OFS_W < ROFS_W) begin : g_bad_ofs
      $error("seg_xlate_unit: OFS_W must cover the real-mode offset");
   end

   logic              mode_q;
   logic [SEL_W-1:0]  cur_sel;
   logic [BASE_W-1:0] cur_base;
   logic [LIM_W-1:0]  cur_lim;
   seg_perm_t         cur_perm;
   logic [SEL_W-1:0]  cs_sel;
   logic              rej_now;
   logic [BASE_W-1:0] real_addr;
   logic [BASE_W-1:0] prot_addr;
   fault_e            prot_fault;
   seg_perm_t         fill_perm;

   assign fill_perm = '{present: fill_present, rd_ok: fill_read, wr_ok: fill_write};

   seg_bank #(
      .NSEG(NSEG), .SEL_W(SEL_W), .BASE_W(BASE_W), .LIM_W(LIM_W), .IDX_W(IDX_W)
   ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .dwr_en(seg_wr_en), .dwr_idx(seg_wr_idx), .dwr_val(seg_wr_val),
      .cs_ld_en(cs_ld_en), .cs_ld_val(cs_ld_val),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_base(fill_base),
      .fill_lim(fill_limit), .fill_perm(fill_perm),
      .rd_idx(req_seg), .rd_sel(cur_sel), .rd_base(cur_base),
      .rd_lim(cur_lim), .rd_perm(cur_perm),
      .code_sel(cs_sel), .dwr_reject(rej_now)
   );

   seg_real_xlate #(
      .SEL_W(SEL_W), .ROFS_W(ROFS_W), .REAL_AW(REAL_AW), .OUT_W(BASE_W)
   ) u_real (
      .sel(cur_sel), .ofs(req_ofs[ROFS_W-1:0]), .addr(real_addr)
   );

   seg_prot_check #(
      .OFS_W(OFS_W), .BASE_W(BASE_W), .LIM_W(LIM_W), .PERM_CHECK(PERM_CHECK)
   ) u_prot (
      .ofs(req_ofs), .is_write(req_write), .base(cur_base), .lim(cur_lim),
      .perm(cur_perm), .addr(prot_addr), .fault(prot_fault)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q    <= 1'b0;
         rsp_valid <= 1'b0;
         rsp_addr  <= '0;
         rsp_fault <= FLT_NONE;
         wr_reject <= 1'b0;
      end else begin
         if (mode_wr) mode_q <= mode_prot;
         wr_reject <= rej_now;
         rsp_valid <= req_valid;
         if (req_valid) begin
            if (!mode_q) begin
               rsp_addr  <= real_addr;
               rsp_fault <= FLT_NONE;
            end else begin
               rsp_addr  <= (prot_fault == FLT_NONE) ? prot_addr : '0;
               rsp_fault <= prot_fault;
            end
         end
      end
   end

endmodule

// File: rtl/seg_xlate_unit_chk.sv
module seg_xlate_unit_chk #(
   parameter int unsigned SEL_W   = 16,
   parameter int unsigned ADDR_W  = 32,
   parameter int unsigned REAL_AW = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic              seg_wr_en,
   input logic [2:0]        seg_wr_idx,
   input logic              cs_ld_en,
   input logic [SEL_W-1:0]  cs_ld_val,
   input logic              mode_q,
   input logic [SEL_W-1:0]  cs_sel,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic [1:0]        rsp_fault,
   input logic              wr_reject
);

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);                                            // R9
   AST_NO_SPURIOUS_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);                                          // R9
   AST_REAL_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !mode_q) |=> (rsp_fault == 2'd0 && rsp_addr[ADDR_W-1:REAL_AW] == '0)); // R2
   AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_fault != 2'd0) |-> rsp_addr == '0);                 // R6
   AST_FAULT_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> rsp_fault != 2'd3);                                    // R6
   AST_CS_GUARD: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_wr_en && seg_wr_idx == 3'd0 && !cs_ld_en) |=> ($stable(cs_sel) && wr_reject)); // R7
   AST_REJECT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_reject |-> $past(seg_wr_en));                                     // R7
   AST_CS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      cs_ld_en |=> cs_sel == $past(cs_ld_val));                            // R8

endmodule

bind seg_xlate_unit seg_xlate_unit_chk #(
   .SEL_W(SEL_W), .ADDR_W(BASE_W), .REAL_AW(REAL_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
   .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx),
   .cs_ld_en(cs_ld_en), .cs_ld_val(cs_ld_val),
   .mode_q(mode_q), .cs_sel(cs_sel),
   .rsp_valid(rsp_valid), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
   .wr_reject(wr_reject)
);

// File: tb/seg_xlate_unit_test.sv
module seg_xlate_unit_test;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic        rst_n, mode_wr, mode_prot, seg_wr_en, cs_ld_en, fill_en;
   logic [2:0]  seg_wr_idx, fill_idx, req_seg;
   logic [15:0] seg_wr_val, cs_ld_val;
   logic [31:0] fill_base, req_ofs, rsp_addr;
   logic [19:0] fill_limit;
   logic        fill_present, fill_read, fill_write, req_valid, req_write;
   logic        rsp_valid, wr_reject;
   logic [1:0]  rsp_fault;

   seg_xlate_unit uut (
      .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_prot(mode_prot),
      .seg_wr_en(seg_wr_en), .seg_wr_idx(seg_wr_idx), .seg_wr_val(seg_wr_val),
      .cs_ld_en(cs_ld_en), .cs_ld_val(cs_ld_val),
      .fill_en(fill_en), .fill_idx(fill_idx), .fill_base(fill_base),
      .fill_limit(fill_limit), .fill_present(fill_present),
      .fill_read(fill_read), .fill_write(fill_write),
      .req_valid(req_valid), .req_seg(req_seg), .req_ofs(req_ofs),
      .req_write(req_write), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
      .rsp_fault(rsp_fault), .wr_reject(wr_reject)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [31:0] q_addr[$];
   logic [1:0]  q_flt[$];
   string       q_tag[$];

   task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   // Driver: presents a request and queues what the requirements predict.
   task automatic issue(input logic [2:0] s, input logic [31:0] o, input bit w,
                        input logic [31:0] ea, input logic [1:0] ef, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_seg = s; req_ofs = o; req_write = w;
      q_addr.push_back(ea); q_flt.push_back(ef); q_tag.push_back(tag);
   endtask

   task automatic idle();
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic dwrite(input logic [2:0] idx, input logic [15:0] v, input bit rej, input string tag);
      @(negedge clk);
      seg_wr_en = 1'b1; seg_wr_idx = idx; seg_wr_val = v;
      @(negedge clk);
      seg_wr_en = 1'b0;
      check(wr_reject === rej, {tag, " wr_reject"}, 32'(wr_reject), 32'(rej));
   endtask

   task automatic fill(input logic [2:0] idx, input logic [31:0] b, input logic [19:0] l,
                       input bit p, input bit r, input bit w);
      @(negedge clk);
      fill_en = 1'b1; fill_idx = idx; fill_base = b; fill_limit = l;
      fill_present = p; fill_read = r; fill_write = w;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic set_mode(input bit prot);
      @(negedge clk);
      mode_wr = 1'b1; mode_prot = prot;
      @(negedge clk);
      mode_wr = 1'b0;
   endtask

   // Monitor: compares each response with the oldest queued prediction.
   initial begin
      forever begin
         @(posedge clk);
         #5;
         if (rst_n === 1'b1) begin
            if (q_addr.size() > 0) begin
               logic [31:0] ea;
               logic [1:0]  ef;
               string       tg;
               ea = q_addr.pop_front(); ef = q_flt.pop_front(); tg = q_tag.pop_front();
               check(rsp_valid === 1'b1, {tg, " R9 rsp_valid"}, 32'(rsp_valid), 32'd1);
               check(rsp_addr === ea, {tg, " addr"}, rsp_addr, ea);
               check(rsp_fault === ef, {tg, " fault"}, 32'(rsp_fault), 32'(ef));
            end else if (rsp_valid !== 1'b0) begin
               check(1'b0, "R9 response without request", 32'(rsp_valid), 32'd0);
            end
         end
      end
   end

   initial begin
      repeat (5000) @(posedge clk);
      check(1'b0, "R9 watchdog expired", 32'd0, 32'd1);
      summary();
   end

   initial begin
      rst_n = 1'b0; mode_wr = 0; mode_prot = 0; seg_wr_en = 0; cs_ld_en = 0;
      fill_en = 0; seg_wr_idx = 0; fill_idx = 0; req_seg = 0; seg_wr_val = 0;
      cs_ld_val = 0; fill_base = 0; req_ofs = 0; fill_limit = 0;
      fill_present = 0; fill_read = 0; fill_write = 0; req_valid = 0; req_write = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(rsp_valid === 1'b0, "R1 rsp_valid after reset", 32'(rsp_valid), 32'd0);
      check(wr_reject === 1'b0, "R1 wr_reject after reset", 32'(wr_reject), 32'd0);

      // R1: selectors start at zero, real mode
      issue(3'd1, 32'h0000_1234, 0, 32'h0000_1234, 2'd0, "R1 zero selector real");
      issue(3'd5, 32'h0000_00FF, 1, 32'h0000_00FF, 2'd0, "R1 R9 back-to-back");
      idle();

      // R2 / R7: data segment write, upper offset bits ignored
      dwrite(3'd1, 16'h1234, 0, "R7 data write");
      issue(3'd1, 32'hABCD_0005, 0, 32'h0001_2345, 2'd0, "R2 shift-add");
      idle();

      // R7: code segment and bad index refused on data path
      dwrite(3'd0, 16'hF000, 1, "R7 code via data");
      dwrite(3'd7, 16'h4444, 1, "R7 bad index");
      issue(3'd0, 32'h0000_0010, 0, 32'h0000_0010, 2'd0, "R7 code selector unchanged");
      idle();

      // R8: control-flow load together with a data write
      @(negedge clk);
      cs_ld_en = 1'b1; cs_ld_val = 16'hF000;
      seg_wr_en = 1'b1; seg_wr_idx = 3'd1; seg_wr_val = 16'h2000;
      @(negedge clk);
      cs_ld_en = 1'b0; seg_wr_en = 1'b0;
      check(wr_reject === 1'b0, "R8 no reject on control load", 32'(wr_reject), 32'd0);
      issue(3'd0, 32'h0000_FFF0, 0, 32'h000F_FFF0, 2'd0, "R8 code loaded");
      issue(3'd1, 32'h0000_0003, 0, 32'h0002_0003, 2'd0, "R8 data loaded same cycle");
      idle();

      // R3: wrap; R7: remaining data segments
      dwrite(3'd2, 16'hFFFF, 0, "R7 stack write");
      dwrite(3'd3, 16'h0001, 0, "R7 extra write");
      dwrite(3'd4, 16'hB800, 0, "R7 exf write");
      dwrite(3'd5, 16'h8000, 0, "R7 exg write");
      issue(3'd2, 32'h0000_FFFF, 0, 32'h0000_FFEF, 2'd0, "R3 wrap FFFF:FFFF");
      issue(3'd3, 32'h0000_FFFF, 0, 32'h0001_000F, 2'd0, "R2 carry into bit16");
      issue(3'd4, 32'h0000_0000, 1, 32'h000B_8000, 2'd0, "R2 exf");
      issue(3'd5, 32'h0000_8000, 0, 32'h0008_8000, 2'd0, "R2 exg");
      idle();

      // R10: descriptor fills leave real translation alone
      fill(3'd1, 32'h0010_0000, 20'h00FFF, 1, 1, 1);
      fill(3'd3, 32'h0020_0000, 20'h000FF, 1, 1, 0);
      fill(3'd4, 32'h0030_0000, 20'hFFFFF, 0, 1, 1);
      fill(3'd5, 32'hFFFF_F000, 20'hFFFFF, 1, 1, 1);
      fill(3'd0, 32'h0000_0000, 20'hFFFFF, 1, 0, 0);
      issue(3'd1, 32'h0000_0003, 0, 32'h0002_0003, 2'd0, "R10 real unchanged by fill");
      idle();

      // R4..R6: protected mode
      set_mode(1'b1);
      issue(3'd1, 32'h0000_0010, 0, 32'h0010_0010, 2'd0, "R4 base plus offset");
      issue(3'd1, 32'h0000_0FFF, 0, 32'h0010_0FFF, 2'd0, "R5 offset at limit");
      issue(3'd1, 32'h0000_1000, 0, 32'h0000_0000, 2'd1, "R5 offset past limit");
      issue(3'd1, 32'h0010_0000, 0, 32'h0000_0000, 2'd1, "R5 upper offset bits past limit");
      issue(3'd1, 32'h0000_0004, 1, 32'h0010_0004, 2'd0, "R4 write allowed");
      issue(3'd3, 32'h0000_0004, 1, 32'h0000_0000, 2'd2, "R6 write to read-only");
      issue(3'd3, 32'h0000_0020, 0, 32'h0020_0020, 2'd0, "R6 read of read-only ok");
      issue(3'd3, 32'h0000_5000, 1, 32'h0000_0000, 2'd2, "R6 access before limit");
      issue(3'd4, 32'h0000_0000, 0, 32'h0000_0000, 2'd2, "R6 not present");
      issue(3'd5, 32'h0000_2000, 0, 32'h0000_1000, 2'd0, "R4 modulo 2^32");
      issue(3'd0, 32'h0000_0000, 0, 32'h0000_0000, 2'd2, "R6 read of non-readable");
      issue(3'd2, 32'h0000_0000, 0, 32'h0000_0000, 2'd2, "R1 R6 unfilled is not present");
      idle();

      // R10: selector write keeps cached descriptor in protected mode
      dwrite(3'd1, 16'h0008, 0, "R10 selector write");
      issue(3'd1, 32'h0000_0010, 0, 32'h0010_0010, 2'd0, "R10 cache independent of selector");
      idle();

      // R4: back to real mode
      set_mode(1'b0);
      issue(3'd1, 32'h0000_0000, 0, 32'h0000_0080, 2'd0, "R4 real again");
      idle();

      repeat (3) @(negedge clk);
      summary();
   end

endmodule